// File: doc/BRIEF.md
# Interrupt Program-Counter Switcher

This block takes the interrupt requests of a set of expansion slots on a processor that alternates fetch and execute cycles. The processor has no return-address push on interrupt entry. Instead, the block tells the fetch logic which register-file entry acts as the program counter. Normally that entry is register 7. While an interrupt is being serviced it is register 6, which software must load with the service routine entry address before it turns interrupts on.

Requests are combined into one shared interrupt, and the lowest-numbered requesting slot is recorded as the winner. The switch happens only on a fetch boundary, so an instruction is never split. The service routine ends with a clear pulse. The processor keeps using register 6 until the next fetch boundary and then goes back to register 7. Saving the flags and the register file itself are handled elsewhere.

Top module: `irq_pc_switch`

## Requirements
- R1: After reset, `pc_sel_o` is 7, `in_service_o` is 0, `winner_o` is 0, and interrupts are disabled.
- R2: Interrupt entry happens only at a rising edge where `fetch_next_i` is 1. A pending enabled request with `fetch_next_i` at 0 changes nothing.
- R3: On entry, `winner_o` holds the binary index of the lowest-numbered slot whose `slot_req_i` bit is 1.
- R4: While interrupts are disabled, requests have no effect. They are disabled from reset, and after any cycle with `irq_disable_i` at 1, until a later cycle with only `irq_enable_i` at 1. An enable pulse takes effect from the following cycle.
- R5: While in service, further requests are ignored and `winner_o` holds its value.
- R6: A clear pulse while in service causes the return at the first rising edge with `fetch_next_i` at 1. That edge can be the one in the same cycle as the pulse. Until that edge, `pc_sel_o` stays 6.
- R7: If `irq_enable_i` and `irq_disable_i` are both 1 in one cycle, interrupts end up disabled.
- R8: A clear pulse while not in service is discarded. It does not shorten a later service period.
- R9: `pc_sel_o` is 6 whenever `in_service_o` is 1, and 7 otherwise. `winner_o` is 0 when not in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| slot_req_i | input | 8 | Request line of each slot; bit n belongs to slot n |
| irq_enable_i | input | 1 | One-cycle pulse that turns interrupts on |
| irq_disable_i | input | 1 | One-cycle pulse that turns interrupts off |
| irq_clear_i | input | 1 | One-cycle pulse sent by the service routine when it finishes |
| fetch_next_i | input | 1 | 1 in a cycle whose successor is a fetch cycle |
| pc_sel_o | output | 3 | Register index to use as the program counter |
| in_service_o | output | 1 | 1 while an interrupt is being serviced |
| winner_o | output | 3 | Index of the slot that was granted |

## Verification
The bench drives single-slot requests, several simultaneous requests, and a request on the highest slot alone. This separates lowest-index priority from a plain bit reduction. Requests are applied both off and on fetch boundaries, so entry at the wrong phase shows up. Clear pulses are applied before, and together with, a fetch boundary, which exposes whether the return is delayed. A clear while idle is followed by a service period that must last past one fetch boundary. Requests are also made after a disable pulse and after a combined enable/disable pulse, which must both leave the program counter at register 7.

// File: rtl/irq_pc_pkg.sv
package irq_pc_pkg;
  typedef enum logic [1:0] {
    SVC_IDLE  = 2'd0,
    SVC_RUN   = 2'd1,
    SVC_LEAVE = 2'd2
  } svc_state_e;
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic en_pulse_i,
  input  logic dis_pulse_i,
  output logic enabled_o
);
  logic en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (dis_pulse_i)     en_d = 1'b0;
    else if (en_pulse_i) en_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign enabled_o = en_q;

  assert_dis_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dis_pulse_i |=> !enabled_o);
endmodule

// File: rtl/irq_slot_prio.sv
module irq_slot_prio #(
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] req_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     idx_o
);
  logic [NUM_SLOTS-1:0] grant;

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_grant
      if (g == 0) begin : g_first
        assign grant[g] = req_i[g];
      end else begin : g_rest
        assign grant[g] = req_i[g] & ~(|req_i[g-1:0]);
      end
    end
  endgenerate

  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end

  assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any_o == (|grant)));
  assert_grant_matches_idx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> grant[idx_o]);
endmodule

// File: rtl/irq_svc_fsm.sv
module irq_svc_fsm
  import irq_pc_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_next_i,
  input  logic             enabled_i,
  input  logic             any_req_i,
  input  logic [IDX_W-1:0] req_idx_i,
  input  logic             clear_i,
  output logic             in_service_o,
  output logic [IDX_W-1:0] winner_o
);
  svc_state_e st_q, st_d;
  logic [IDX_W-1:0] win_q, win_d;
  logic             win_en;

  always_comb begin
    st_d   = st_q;
    win_en = 1'b0;
    win_d  = win_q;
    unique case (st_q)
      SVC_IDLE: begin
        if (fetch_next_i && enabled_i && any_req_i) begin
          st_d   = SVC_RUN;
          win_en = 1'b1;
          win_d  = req_idx_i;
        end
      end
      SVC_RUN: begin
        if (clear_i) st_d = fetch_next_i ? SVC_IDLE : SVC_LEAVE;
      end
      SVC_LEAVE: begin
        if (fetch_next_i) st_d = SVC_IDLE;
      end
      default: st_d = SVC_IDLE;
    endcase
    if (st_d == SVC_IDLE && st_q != SVC_IDLE) begin
      win_en = 1'b1;
      win_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SVC_IDLE;
      win_q <= '0;
    end else begin
      st_q <= st_d;
      if (win_en) win_q <= win_d;
    end
  end

  assign in_service_o = (st_q != SVC_IDLE);
  assign winner_o     = win_q;

  assert_entry_on_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_service_o) |-> $past(fetch_next_i));
  assert_return_on_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_service_o) |-> $past(fetch_next_i));
  assert_winner_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service_o && $past(in_service_o)) |-> $stable(winner_o));
  assert_idle_winner_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_service_o |-> (winner_o == '0));
endmodule

// File: rtl/irq_pc_switch.sv
module irq_pc_switch #(
  parameter int NUM_SLOTS  = 8,
  parameter int PC_IDX_W   = 3,
  parameter int NORMAL_PC  = 7,
  parameter int SERVICE_PC = 6,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] slot_req_i,
  input  logic                 irq_enable_i,
  input  logic                 irq_disable_i,
  input  logic                 irq_clear_i,
  input  logic                 fetch_next_i,
  output logic [PC_IDX_W-1:0]  pc_sel_o,
  output logic                 in_service_o,
  output logic [IDX_W-1:0]     winner_o
);
  logic rst_meta, rst_sync_n;
  logic enabled, any_req;
  logic [IDX_W-1:0] req_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  irq_enable_reg u_en (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .en_pulse_i (irq_enable_i),
    .dis_pulse_i(irq_disable_i),
    .enabled_o  (enabled)
  );

  irq_slot_prio #(.NUM_SLOTS(NUM_SLOTS)) u_prio (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .req_i(slot_req_i),
    .any_o(any_req),
    .idx_o(req_idx)
  );

  irq_svc_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .fetch_next_i(fetch_next_i),
    .enabled_i   (enabled),
    .any_req_i   (any_req),
    .req_idx_i   (req_idx),
    .clear_i     (irq_clear_i),
    .in_service_o(in_service_o),
    .winner_o    (winner_o)
  );

  assign pc_sel_o = in_service_o ? PC_IDX_W'(SERVICE_PC) : PC_IDX_W'(NORMAL_PC);

  assert_no_entry_disabled_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(in_service_o) |-> $past(enabled) && $past(any_req));
  assert_pc_in_service_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_service_o |-> (pc_sel_o == PC_IDX_W'(SERVICE_PC)));
endmodule

// File: tb/tb_irq_pc_switch.sv
module tb_irq_pc_switch;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] req;
  logic       en, dis, clr, fn;
  logic [2:0] pc_sel, winner;
  logic       ins;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  irq_pc_switch dut (
    .clk(clk), .rst_n(rst_n), .slot_req_i(req), .irq_enable_i(en),
    .irq_disable_i(dis), .irq_clear_i(clr), .fetch_next_i(fn),
    .pc_sel_o(pc_sel), .in_service_o(ins), .winner_o(winner)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // expected state: pc/in_service consistency (R9) checked together
  task automatic chk_state(input string tag, input bit svc, input int win);
    chk({tag, " pc_sel (R9)"}, pc_sel, svc ? 6 : 7);
    chk({tag, " in_service"}, ins, svc);
    chk({tag, " winner"}, winner, win);
  endtask

  // apply inputs for one cycle, then idle them; outputs sampled afterwards
  task automatic cyc(input logic [7:0] r, input bit e, input bit d, input bit c, input bit f);
    req = r; en = e; dis = d; clr = c; fn = f;
    @(negedge clk);
    req = '0; en = 0; dis = 0; clr = 0; fn = 0;
  endtask

  task automatic t_reset;
    chk_state("R1 reset", 0, 0);
  endtask

  task automatic t_disabled;
    cyc(8'h08, 0, 0, 0, 1);
    cyc(8'h08, 0, 0, 0, 1);
    chk_state("R4 disabled after reset", 0, 0);
  endtask

  task automatic t_entry_phase;
    cyc(8'h00, 1, 0, 0, 0);
    cyc(8'h08, 0, 0, 0, 0);
    cyc(8'h08, 0, 0, 0, 0);
    chk_state("R2 no entry off fetch", 0, 0);
    cyc(8'h08, 0, 0, 0, 1);
    chk_state("R2 entry on fetch", 1, 3);
  endtask

  task automatic t_in_service;
    cyc(8'h01, 0, 0, 0, 1);
    cyc(8'hFF, 0, 0, 0, 1);
    chk_state("R5 requests ignored in service", 1, 3);
  endtask

  task automatic t_clear_delayed;
    cyc(8'h00, 0, 0, 1, 0);
    chk_state("R6 clear waits for fetch", 1, 3);
    cyc(8'h00, 0, 0, 0, 0);
    chk_state("R6 still waiting", 1, 3);
    cyc(8'h00, 0, 0, 0, 1);
    chk_state("R6 returned at fetch", 0, 0);
  endtask

  task automatic t_priority;
    cyc(8'hB4, 0, 0, 0, 1);
    chk_state("R3 lowest of 0xB4", 1, 2);
    cyc(8'h00, 0, 0, 1, 1);
    chk_state("R6 clear with fetch same cycle", 0, 0);
    cyc(8'h80, 0, 0, 0, 1);
    chk_state("R3 top slot alone", 1, 7);
    cyc(8'h00, 0, 0, 1, 1);
    cyc(8'h60, 0, 0, 0, 1);
    chk_state("R3 lowest of 0x60", 1, 5);
    cyc(8'h00, 0, 0, 1, 1);
    chk_state("R6 back to idle", 0, 0);
  endtask

  task automatic t_idle_clear;
    cyc(8'h00, 0, 0, 1, 0);
    cyc(8'h00, 0, 0, 0, 0);
    cyc(8'h02, 0, 0, 0, 1);
    chk_state("R8 entry after idle clear", 1, 1);
    cyc(8'h00, 0, 0, 0, 1);
    chk_state("R8 stale clear discarded", 1, 1);
    cyc(8'h00, 0, 0, 1, 1);
    chk_state("R8 leave", 0, 0);
  endtask

  task automatic t_disable;
    cyc(8'h00, 0, 1, 0, 0);
    cyc(8'h10, 0, 0, 0, 1);
    chk_state("R4 disabled by pulse", 0, 0);
    cyc(8'h00, 1, 1, 0, 0);
    cyc(8'h10, 0, 0, 0, 1);
    chk_state("R7 disable wins", 0, 0);
    cyc(8'h00, 1, 0, 0, 0);
    cyc(8'h10, 0, 0, 0, 1);
    chk_state("R4 re-enabled", 1, 4);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 0; req = '0; en = 0; dis = 0; clr = 0; fn = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_disabled();
    t_entry_phase();
    t_in_service();
    t_clear_delayed();
    t_priority();
    t_idle_clear();
    t_disable();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule